// File: doc/BRIEF.md
# Cascadable Interval Timer Pair

Two 8-bit interval timer channels that share one register write port. Each channel counts up on a count clock it chooses with a 3-bit select field: one of several prescaled tick strobes, a tick on every clock, or rising edges on its own external event input. The running count is compared at all times with a compare value that software writes. On a match the channel raises a one-cycle interrupt pulse. It can also clear its count and toggle an output flip-flop. Software can force that flip-flop high or low at any time, and the flip-flop reaches the output pin only while the output enable is set. A wrap of the count past its maximum gives a one-cycle overflow pulse.

If cascade mode is set in the upper channel, the two channels act as one 16-bit timer. The upper half advances each time the lower half wraps. A match needs both halves to be equal to their compare values. The clear, interrupt and output behaviour of the pair then follow the upper channel's settings, and the lower channel's interrupt stays silent.

Top module: `cascade_interval_timer`

## Requirements
- R1: After reset every output is low, both counts are zero and neither channel counts.
- R2: A write sets one register on the write strobe edge. wrAddr[2] picks the channel, and wrAddr[1:0] picks the register: 0 control, 1 compare, 2 clock select. The control bits are: 0 count enable, 1 clear on match, 2 invert on match, 3 output enable, 4 level set, 5 level reset, 6 cascade (honoured in channel 1 only).
- R3: The clock select codes are 0 to 5 for prescaler tap 0 to 5, 6 for every clock cycle, and 7 for a rising edge of the channel's event input. Taps that are not selected have no effect.
- R4: A count edge on which the count equals the compare value gives a one-cycle interrupt pulse in the next cycle. If clear on match is set, the count returns to 0 instead of advancing. The first interrupt after enabling therefore comes compare+1 count edges later, and the next ones follow at the same spacing.
- R5: With clear on match off, the count wraps from 255 to 0. The wrap gives a one-cycle overflow pulse after which the count reads 0, and the interrupt repeats every 256 count edges.
- R6: A compare value of 0 with clear on match gives an interrupt on every count edge.
- R7: A new compare value takes effect from the cycle after the write, even while the channel counts.
- R8: Clearing count enable resets the count to 0. Counting starts again from 0 when the enable is set again.
- R9: While invert is set, every interrupt-producing match toggles the output flip-flop on the same edge that raises the interrupt.
- R10: Level set forces the flip-flop high and level reset forces it low. A control write with both bits set leaves the flip-flop unchanged.
- R11: While output enable is clear the timer output is low, but the flip-flop keeps its state and keeps toggling. Setting the enable shows the flip-flop's state on the output.
- R12: In cascade mode the pair counts as one 16-bit value with channel 0 as the low byte. A match needs both bytes to match. Clearing and the interrupt use channel 1's settings, so the interrupt repeats every (cmp1*256+cmp0+1) lower count edges. matchIrq[0] stays low, and channel 0's own clear bit has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Channel and register select |
| wrData | input | CNT_W | Write data |
| prescTick | input | NUM_TAPS | Prescaled tick strobes, one per tap |
| evtIn | input | 2 | External event input per channel |
| matchIrq | output | 2 | Match interrupt pulse per channel |
| ovfPulse | output | 2 | Count wrap pulse per channel |
| timerOut | output | 2 | Gated output flip-flop per channel |

## Verification
The bench uses the default parameters: CNT_W=8, NUM_TAPS=6 and CSEL_W=3. With an 8-bit count, the free-running wrap takes 256 count edges, and the 16-bit cascade match at compare 0x0120 takes 289 cycles, so both are reached in a short run. With six taps, codes 6 and 7 select the every-cycle and event sources. The bench can then run the tap path, with random tap indices and periods while the other taps tick every cycle, next to a deterministic every-cycle path used for the compare and output checks.

// File: rtl/cit_pkg.sv
package cit_pkg;

  localparam int unsigned CH_NUM = 2;
  localparam int unsigned ADDR_W = 3;

  localparam int unsigned BIT_CE   = 0;
  localparam int unsigned BIT_CLR  = 1;
  localparam int unsigned BIT_INV  = 2;
  localparam int unsigned BIT_OE   = 3;
  localparam int unsigned BIT_LSET = 4;
  localparam int unsigned BIT_LRST = 5;
  localparam int unsigned BIT_CASC = 6;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CMP  = 2'd1,
    REG_CSEL = 2'd2,
    REG_NONE = 2'd3
  } regSel_e;

  // per-channel strobes from control to datapath
  typedef struct packed {
    logic enable;
    logic tick;
    logic clear;
    logic hit;
    logic setLvl;
    logic rstLvl;
    logic invert;
    logic outEn;
  } chStrobe_t;

endpackage

// File: rtl/cit_datapath.sv
module cit_datapath
  import cit_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  chStrobe_t        strobe,
  input  logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] cnt,
  output logic             matchRaw,
  output logic             irq,
  output logic             ovf,
  output logic             ffQ,
  output logic             timerOut
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic atMax;

  assign matchRaw = (cnt == cmpVal);
  assign atMax    = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!strobe.enable) begin
      cnt <= '0;
    end else if (strobe.clear) begin
      cnt <= '0;
    end else if (strobe.tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq <= 1'b0;
      ovf <= 1'b0;
    end else begin
      irq <= strobe.enable & strobe.hit;
      ovf <= strobe.enable & strobe.tick & atMax & ~strobe.clear;
    end
  end

  // output flip-flop: software level wins over toggle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ffQ <= 1'b0;
    end else if (strobe.setLvl) begin
      ffQ <= 1'b1;
    end else if (strobe.rstLvl) begin
      ffQ <= 1'b0;
    end else if (strobe.hit && strobe.invert) begin
      ffQ <= ~ffQ;
    end
  end

  assign timerOut = ffQ & strobe.outEn;

endmodule

// File: rtl/cit_ctrl.sv
module cit_ctrl
  import cit_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned NUM_TAPS = 6,
  parameter int unsigned CSEL_W   = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [CNT_W-1:0]               wrData,
  input  logic [NUM_TAPS-1:0]            prescTick,
  input  logic [CH_NUM-1:0]              evtIn,
  input  logic [CH_NUM-1:0]              matchRaw,
  input  logic                           lowAtMax,
  output logic [CH_NUM-1:0][CNT_W-1:0]   cmpVal,
  output chStrobe_t [CH_NUM-1:0]         strobe,
  output logic                           cascadeOn
);

  localparam logic [CSEL_W-1:0] SEL_EVT = {CSEL_W{1'b1}};

  logic [CH_NUM-1:0]              enQ, clrQ, invQ, oenQ;
  logic [CH_NUM-1:0]              evtPrev, evtEdge, srcTick, ctrlWr;
  logic [CH_NUM-1:0][CSEL_W-1:0]  cselQ;
  logic                           cascQ;
  regSel_e                        regSel;

  assign regSel    = regSel_e'(wrAddr[1:0]);
  assign evtEdge   = evtIn & ~evtPrev;
  assign cascadeOn = cascQ;

  function automatic logic pickTick(input logic [CSEL_W-1:0] sel,
                                    input logic [NUM_TAPS-1:0] taps,
                                    input logic edgeHit);
    logic r;
    r = 1'b1;
    if (sel == SEL_EVT) begin
      r = edgeHit;
    end else begin
      for (int k = 0; k < NUM_TAPS; k++) begin
        if (sel == CSEL_W'(k)) r = taps[k];
      end
    end
    return r;
  endfunction

  always_comb begin
    for (int c = 0; c < CH_NUM; c++) begin
      ctrlWr[c] = wrEn && (wrAddr[ADDR_W-1] == 1'(c)) && (regSel == REG_CTRL);
    end
  end

  for (genvar g = 0; g < CH_NUM; g++) begin : g_src
    assign srcTick[g] = pickTick(cselQ[g], prescTick, evtEdge[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ     <= '0;
      clrQ    <= '0;
      invQ    <= '0;
      oenQ    <= '0;
      cselQ   <= '0;
      cmpVal  <= '0;
      evtPrev <= '0;
      cascQ   <= 1'b0;
    end else begin
      evtPrev <= evtIn;
      for (int c = 0; c < CH_NUM; c++) begin
        if (wrEn && (wrAddr[ADDR_W-1] == 1'(c))) begin
          unique case (regSel)
            REG_CTRL: begin
              enQ[c]  <= wrData[BIT_CE];
              clrQ[c] <= wrData[BIT_CLR];
              invQ[c] <= wrData[BIT_INV];
              oenQ[c] <= wrData[BIT_OE];
            end
            REG_CMP:  cmpVal[c] <= wrData;
            REG_CSEL: cselQ[c]  <= wrData[CSEL_W-1:0];
            default: ;
          endcase
        end
      end
      if (ctrlWr[CH_NUM-1]) cascQ <= wrData[BIT_CASC];
    end
  end

  // count routing: independent channels or one 16-bit pair
  logic tick0, tick1Own, pairHit;
  logic hit0, clr0, hit1, clr1, tick1;

  assign tick0    = enQ[0] & srcTick[0];
  assign tick1Own = enQ[1] & srcTick[1];
  assign pairHit  = tick0 & matchRaw[0] & matchRaw[1];

  always_comb begin
    if (cascQ) begin
      hit0  = 1'b0;
      clr0  = pairHit & clrQ[1];
      hit1  = pairHit & enQ[1];
      clr1  = hit1 & clrQ[1];
      tick1 = enQ[1] & tick0 & lowAtMax & ~clr0;
    end else begin
      hit0  = tick0 & matchRaw[0];
      clr0  = hit0 & clrQ[0];
      hit1  = tick1Own & matchRaw[1];
      clr1  = hit1 & clrQ[1];
      tick1 = tick1Own;
    end
  end

  always_comb begin
    for (int c = 0; c < CH_NUM; c++) begin
      strobe[c].enable = enQ[c];
      strobe[c].invert = invQ[c];
      strobe[c].outEn  = oenQ[c];
      strobe[c].setLvl = ctrlWr[c] & wrData[BIT_LSET] & ~wrData[BIT_LRST];
      strobe[c].rstLvl = ctrlWr[c] & wrData[BIT_LRST] & ~wrData[BIT_LSET];
    end
    strobe[0].tick  = tick0;
    strobe[0].clear = clr0;
    strobe[0].hit   = hit0;
    strobe[1].tick  = tick1;
    strobe[1].clear = clr1;
    strobe[1].hit   = hit1;
  end

endmodule

// File: rtl/cascade_interval_timer.sv
module cascade_interval_timer
  import cit_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned NUM_TAPS = 6,
  parameter int unsigned CSEL_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [2:0]          wrAddr,
  input  logic [CNT_W-1:0]    wrData,
  input  logic [NUM_TAPS-1:0] prescTick,
  input  logic [1:0]          evtIn,
  output logic [1:0]          matchIrq,
  output logic [1:0]          ovfPulse,
  output logic [1:0]          timerOut
);

  chStrobe_t [CH_NUM-1:0]            strobeAll;
  logic [CH_NUM-1:0][CNT_W-1:0]      cmpAll;
  logic [CH_NUM-1:0][CNT_W-1:0]      cntAll;
  logic [CH_NUM-1:0]                 matchAll, ffAll;
  logic [CH_NUM-1:0]                 enAll, setAll, rstAll, flipAll, hitAll;
  logic                              cascadeOn;

  cit_ctrl #(
    .CNT_W    (CNT_W),
    .NUM_TAPS (NUM_TAPS),
    .CSEL_W   (CSEL_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .prescTick (prescTick),
    .evtIn     (evtIn),
    .matchRaw  (matchAll),
    .lowAtMax  (&cntAll[0]),
    .cmpVal    (cmpAll),
    .strobe    (strobeAll),
    .cascadeOn (cascadeOn)
  );

  for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
    cit_datapath #(
      .CNT_W (CNT_W)
    ) u_dp (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobeAll[g]),
      .cmpVal   (cmpAll[g]),
      .cnt      (cntAll[g]),
      .matchRaw (matchAll[g]),
      .irq      (matchIrq[g]),
      .ovf      (ovfPulse[g]),
      .ffQ      (ffAll[g]),
      .timerOut (timerOut[g])
    );
    assign enAll[g]   = strobeAll[g].enable;
    assign setAll[g]  = strobeAll[g].setLvl;
    assign rstAll[g]  = strobeAll[g].rstLvl;
    assign hitAll[g]  = strobeAll[g].hit;
    assign flipAll[g] = strobeAll[g].hit & strobeAll[g].invert;
  end

endmodule

// File: rtl/cit_checker.sv
module cit_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [2:0]            wrAddr,
  input logic [1:0]            wrLvl,
  input logic [1:0][CNT_W-1:0] cnt,
  input logic [1:0]            enable,
  input logic [1:0]            setLvl,
  input logic [1:0]            rstLvl,
  input logic [1:0]            flip,
  input logic [1:0]            hit,
  input logic [1:0]            ffState,
  input logic [1:0]            matchIrq,
  input logic [1:0]            ovfPulse,
  input logic                  cascadeOn
);

  for (genvar c = 0; c < 2; c++) begin : g_chk
    assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
      !enable[c] |=> cnt[c] == '0);

    assert_ovf_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
      ovfPulse[c] |-> cnt[c] == '0);

    assert_irq_hit_R4: assert property (@(posedge clk) disable iff (!rstN)
      matchIrq[c] |-> $past(hit[c]));

    assert_lvl_set_R10: assert property (@(posedge clk) disable iff (!rstN)
      setLvl[c] |=> ffState[c]);

    assert_lvl_rst_R10: assert property (@(posedge clk) disable iff (!rstN)
      rstLvl[c] |=> !ffState[c]);

    assert_lvl_both_R10: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr[2] == 1'(c) && wrAddr[1:0] == 2'd0 && wrLvl == 2'b11 && !flip[c])
      |=> $stable(ffState[c]));
  end

  assert_casc_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    $past(cascadeOn) |-> !matchIrq[0]);

endmodule

bind cascade_interval_timer cit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrLvl     (wrData[5:4]),
  .cnt       (cntAll),
  .enable    (enAll),
  .setLvl    (setAll),
  .rstLvl    (rstAll),
  .flip      (flipAll),
  .hit       (hitAll),
  .ffState   (ffAll),
  .matchIrq  (matchIrq),
  .ovfPulse  (ovfPulse),
  .cascadeOn (cascadeOn)
);

// File: tb/cascade_interval_timer_tb.sv
module cascade_interval_timer_tb;

  localparam int CNT_W    = 8;
  localparam int NUM_TAPS = 6;
  localparam int CSEL_W   = 3;

  localparam int CE = 1, CLR = 2, INV = 4, OE = 8, LS = 16, LR = 32, CAS = 64;
  localparam int SEL_ALL = 6, SEL_EVT = 7;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                wrEn = 1'b0;
  logic [2:0]          wrAddr = '0;
  logic [CNT_W-1:0]    wrData = '0;
  logic [NUM_TAPS-1:0] prescTick = '0;
  logic [1:0]          evtIn = '0;
  logic [1:0]          matchIrq, ovfPulse, timerOut;

  int total = 0, bad = 0, cyc = 0;
  int irqCnt0 = 0, irqCnt1 = 0;
  int tapIdx = 0, tapPer = 1, tapCnt = 0;
  bit finished = 0;

  cascade_interval_timer #(
    .CNT_W(CNT_W), .NUM_TAPS(NUM_TAPS), .CSEL_W(CSEL_W)
  ) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .prescTick(prescTick), .evtIn(evtIn),
    .matchIrq(matchIrq), .ovfPulse(ovfPulse), .timerOut(timerOut)
  );

  always #4 clk = ~clk;

  // selected tap pulses every tapPer cycles, all others tick every cycle
  always @(negedge clk) begin
    prescTick <= ~(NUM_TAPS'(1) << tapIdx) | ((tapCnt == 0) ? (NUM_TAPS'(1) << tapIdx) : '0);
    if (tapCnt >= tapPer - 1) tapCnt = 0; else tapCnt = tapCnt + 1;
    if (matchIrq[0]) irqCnt0++;
    if (matchIrq[1]) irqCnt1++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int rg, input int data);
    @(negedge clk);
    wrEn   = 1'b1;
    wrAddr = 3'((ch << 2) | rg);
    wrData = CNT_W'(data);
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  task automatic setup(input int ch, input int cmp, input int sel, input int ctl);
    wr(ch, 0, 0);
    wr(ch, 1, cmp);
    wr(ch, 2, sel);
    wr(ch, 0, ctl);
  endtask

  // counts negedges until the chosen pulse is seen
  task automatic waitEvt(input int ch, input bit useOvf, input int start, output int n);
    int j;
    bit seen;
    j = start;
    seen = 0;
    while (!seen && j < 4000) begin
      @(negedge clk);
      if (useOvf ? ovfPulse[ch] : matchIrq[ch]) seen = 1;
      else j++;
    end
    n = j;
  endtask

  task automatic pulseEvt(input int ch, input int n);
    repeat (n) begin
      @(negedge clk); evtIn[ch] = 1'b1;
      @(negedge clk);
      @(negedge clk); evtIn[ch] = 1'b0;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic int expGap(input int cmp, input bit clr, input int per);
    return (clr ? cmp + 1 : 256) * per;
  endfunction

  initial begin
    int n, cmp, base;
    void'($urandom(32'd7331));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(matchIrq == 2'b00 && ovfPulse == 2'b00 && timerOut == 2'b00,
          "R1 reset outputs", int'({matchIrq, ovfPulse, timerOut}), 0);

    // R4 random compare values with clear, every-cycle clock
    for (int i = 0; i < 6; i++) begin
      cmp = $urandom_range(1, 40);
      setup(0, cmp, SEL_ALL, CE | CLR);
      waitEvt(0, 0, 0, n);
      check(n == expGap(cmp, 1, 1), "R4 R1 R2 first match delay", n, expGap(cmp, 1, 1));
      waitEvt(0, 0, 1, n);
      check(n == expGap(cmp, 1, 1), "R4 match period", n, expGap(cmp, 1, 1));
    end

    // R6 compare zero with clear
    setup(0, 0, SEL_ALL, CE | CLR);
    waitEvt(0, 0, 0, n);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(matchIrq[0] == 1'b1, "R6 irq each edge", int'(matchIrq[0]), 1);
    end

    // R5 free run with wrap
    cmp = $urandom_range(2, 200);
    setup(0, cmp, SEL_ALL, CE);
    waitEvt(0, 1, 0, n);
    check(n == 256, "R5 first overflow", n, 256);
    waitEvt(0, 0, 1, n);
    check(n == cmp + 1, "R5 match after wrap", n, cmp + 1);
    waitEvt(0, 0, 1, n);
    check(n == expGap(cmp, 0, 1), "R5 free-run period", n, expGap(cmp, 0, 1));

    // R3 prescaler taps, other taps busy every cycle
    for (int i = 0; i < 4; i++) begin
      tapIdx = $urandom_range(0, NUM_TAPS - 1);
      tapPer = $urandom_range(2, 5);
      cmp = $urandom_range(1, 6);
      setup(0, cmp, tapIdx, CE | CLR);
      waitEvt(0, 0, 0, n);
      waitEvt(0, 0, 1, n);
      check(n == expGap(cmp, 1, tapPer), "R3 tap period", n, expGap(cmp, 1, tapPer));
    end
    tapIdx = 0;
    tapPer = 1;

    // R3 external event edges
    setup(0, 3, SEL_EVT, CE | CLR);
    base = irqCnt0;
    repeat (10) @(negedge clk);
    check(irqCnt0 == base, "R3 no event no count", irqCnt0 - base, 0);
    pulseEvt(0, 4);
    check(irqCnt0 - base == 1, "R3 four events one irq", irqCnt0 - base, 1);
    pulseEvt(0, 3);
    check(irqCnt0 - base == 1, "R3 three more events", irqCnt0 - base, 1);
    pulseEvt(0, 1);
    check(irqCnt0 - base == 2, "R3 eighth event", irqCnt0 - base, 2);

    // R7 compare write while counting
    setup(0, 10, SEL_ALL, CE | CLR);
    waitEvt(0, 0, 0, n);
    wr(0, 1, 7);
    waitEvt(0, 0, 0, n);
    check(n == 6, "R7 new compare used at once", n, 6);
    waitEvt(0, 0, 1, n);
    check(n == 8, "R7 new period", n, 8);

    // R8 disable resets count
    setup(0, 20, SEL_ALL, CE | CLR);
    repeat (10) @(negedge clk);
    wr(0, 0, CLR);
    wr(0, 0, CE | CLR);
    waitEvt(0, 0, 0, n);
    check(n == 21, "R8 restart from zero", n, 21);

    // R9 toggle on match
    wr(0, 0, OE | LR);
    @(negedge clk);
    check(timerOut[0] == 1'b0, "R10 level reset", int'(timerOut[0]), 0);
    setup(0, 4, SEL_ALL, CE | CLR | INV | OE);
    waitEvt(0, 0, 0, n);
    check(timerOut[0] == 1'b1, "R9 toggle high with irq", int'(timerOut[0]), 1);
    waitEvt(0, 0, 1, n);
    check(timerOut[0] == 1'b0, "R9 toggle low with irq", int'(timerOut[0]), 0);

    // R11 gating keeps flip-flop running
    wr(0, 0, CE | CLR | INV);
    waitEvt(0, 0, 0, n);
    check(timerOut[0] == 1'b0, "R11 gated low", int'(timerOut[0]), 0);
    wr(0, 0, OE);
    @(negedge clk);
    check(timerOut[0] == 1'b1, "R11 state kept", int'(timerOut[0]), 1);

    // R10 level controls
    wr(0, 0, OE | LR);
    @(negedge clk);
    check(timerOut[0] == 1'b0, "R10 reset", int'(timerOut[0]), 0);
    wr(0, 0, OE | LS | LR);
    @(negedge clk);
    check(timerOut[0] == 1'b0, "R10 both ignored low", int'(timerOut[0]), 0);
    wr(0, 0, OE | LS);
    @(negedge clk);
    check(timerOut[0] == 1'b1, "R10 set", int'(timerOut[0]), 1);
    wr(0, 0, OE | LS | LR);
    @(negedge clk);
    check(timerOut[0] == 1'b1, "R10 both ignored high", int'(timerOut[0]), 1);

    // R12 cascade 16-bit match at 0x0120
    wr(0, 0, 0);
    setup(1, 1, SEL_EVT, CAS | CE | CLR);
    base = irqCnt0;
    setup(0, 32'h20, SEL_ALL, CE | CLR);
    waitEvt(1, 0, 0, n);
    check(n == 289, "R12 cascade first match", n, 289);
    waitEvt(1, 0, 1, n);
    check(n == 289, "R12 cascade period", n, 289);
    check(irqCnt0 == base, "R12 lower irq silent", irqCnt0 - base, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule